// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the memory-side controller for synchronous burst reads from a 32-bit word array. A host marks a new access by pulling the latch-enable input low. On the first active clock edge that sees it low, the block captures a 19-bit start address. It then counts a programmable first-access latency and puts the first word on the data output. After that, an active-low advance input steps an internal address counter one word per sampled edge. When advance is high the word is held, and a programmable inter-word latency decides when advance is looked at again.

The array sits outside the sequencer as a combinational read port. The block drives `mem_addr` and registers the returned `mem_rdata` onto `dq` only when a new word becomes valid, so `dq` keeps its last value at all other times. A ready flag shows when valid data is on the bus, or is about to be. Configuration inputs control the following:
- which clock edge is active;
- the first and inter-word latencies;
- whether ready rises one cycle early;
- whether synchronous burst mode is enabled at all.

Outside burst mode the ready enable is low, which stands for an undriven ready line.

Top module: `burst_rd_seq`

## Requirements
- R1: When `cfg_fall`=0, all inputs are sampled and all state changes on the rising edge of `clk`. When `cfg_fall`=1, this happens on the falling edge instead.
- R2: A start address is captured on an active edge where `le_n` is low and was high at the previous active edge. The capture starts the first-access wait.
  - Keeping `le_n` low on later edges causes no new capture.
  - A capture during a burst aborts that burst and restarts the wait.
- R3: Count the capture edge as edge 0. After edge X, `dq` equals the array word at the start address. X is `cfg_xlat` when that value is 2 to 7, and 2 when it is 0 or 1. `adv_n` has no effect before edge X.
- R4: During a burst, each sampled edge with `adv_n`=0 increments the address counter and presents the next array word on `dq`.
- R5: A sampled edge with `adv_n`=1 leaves the counter and `dq` unchanged.
  - If `cfg_ylat2`=0, advance is sampled again on the next edge.
  - If `cfg_ylat2`=1, the next edge ignores advance and the edge after that samples it.
- R6: With `cfg_rdy_early`=0, `rdy` is low from the capture edge until edge X, and high from edge X onward. While `rdy` is low, `dq` keeps its previous value.
- R7: With `cfg_rdy_early`=1, `rdy` rises one cycle earlier, after edge X-1.
- R8: With `cfg_sync`=0, `rdy_oe` and `rdy` are 0, the block returns to idle, and `le_n` and `adv_n` are ignored. `dq` keeps its value.
- R9: The 19-bit address counter wraps from 0x7FFFF to 0x00000 when advanced.
- R10: A synchronous active-high `rst` clears `dq` to 0, clears the counter (so `mem_addr` is 0), deasserts `rdy` and enters idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync | input | 1 | Synchronous burst mode enable |
| cfg_fall | input | 1 | 1 selects the falling edge as active |
| cfg_xlat | input | 3 | First-access latency in cycles (values below 2 act as 2) |
| cfg_ylat2 | input | 1 | Inter-word latency: 0 gives 1 cycle, 1 gives 2 cycles |
| cfg_rdy_early | input | 1 | Ready rises one cycle early |
| le_n | input | 1 | Active-low latch enable |
| addr | input | 19 | Start address |
| adv_n | input | 1 | Active-low burst advance |
| mem_addr | output | 19 | Array read address |
| mem_rdata | input | 32 | Array read data |
| dq | output | 32 | Data word |
| rdy | output | 1 | Ready flag |
| rdy_oe | output | 1 | Ready drive enable |

## Verification
The bench covers the following corner cases:
- **Address wrap.** A burst starts two words below the top of the address space and runs past it. A counter that saturated, or widened instead of wrapping, would return the wrong word.
- **Ignored advance.** Advance is held low through the first-access wait and through the inter-word wait slot. A design that sampled it too soon would skip words.
- **Held latch enable and mid-burst capture.** Latch enable is kept low over several edges, and a new capture arrives during a burst. A level-sensitive capture would keep restarting, and a missing abort would leave `rdy` high.
- **Latency and ready corners.** Latency codes 0 and 1, early ready, disabled sync mode and the falling active edge are each driven. An off-by-one in the latency count shows up as `dq` or `rdy` moving a cycle early or late against the bench's cycle model.

// File: rtl/burst_rd_seq.sv
`timescale 1ns/1ps
module burst_rd_seq #(
  parameter int AW   = 19,
  parameter int DW   = 32,
  parameter int XW   = 3,
  parameter int XMIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_sync,
  input  logic          cfg_fall,
  input  logic [XW-1:0] cfg_xlat,
  input  logic          cfg_ylat2,
  input  logic          cfg_rdy_early,
  input  logic          le_n,
  input  logic [AW-1:0] addr,
  input  logic          adv_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] dq,
  output logic          rdy,
  output logic          rdy_oe
);
  localparam logic [XW-1:0] XMIN_V = XW'(XMIN);
  localparam logic [XW-1:0] XONE   = XW'(1);

  typedef enum logic [1:0] {S_IDLE, S_XWAIT, S_BURST, S_YWAIT} st_t;

  logic          aclk;
  st_t           st;
  logic          le_q;
  logic [XW-1:0] xcnt;
  logic [AW-1:0] cnt;
  logic [DW-1:0] dq_q;
  logic [XW-1:0] xl;
  logic          cap, adv_go, x_done;

  assign aclk     = clk ^ cfg_fall;
  assign xl       = (cfg_xlat < XMIN_V) ? XMIN_V : cfg_xlat;
  assign cap      = cfg_sync & ~le_n & le_q;
  assign adv_go   = (st == S_BURST) & ~adv_n & ~cap;
  assign x_done   = (st == S_XWAIT) && (xcnt == xl);
  assign mem_addr = adv_go ? cnt + AW'(1) : cnt;
  assign dq       = dq_q;
  assign rdy_oe   = cfg_sync;
  assign rdy      = cfg_sync & ((st == S_BURST) | (st == S_YWAIT) | (cfg_rdy_early & x_done));

  always_ff @(posedge aclk) begin
    if (rst) begin
      st   <= S_IDLE;
      le_q <= 1'b1;
      xcnt <= '0;
      cnt  <= '0;
      dq_q <= '0;
    end else if (!cfg_sync) begin
      st   <= S_IDLE;
      le_q <= 1'b1;
    end else begin
      le_q <= le_n;
      if (cap) begin
        st   <= S_XWAIT;
        xcnt <= XONE;
        cnt  <= addr;
      end else begin
        case (st)
          S_XWAIT: begin
            if (x_done) begin
              st   <= S_BURST;
              dq_q <= mem_rdata;
            end else begin
              xcnt <= xcnt + XONE;
            end
          end
          S_BURST: begin
            if (adv_go) begin
              cnt  <= mem_addr;
              dq_q <= mem_rdata;
            end else if (cfg_ylat2) begin
              st <= S_YWAIT;
            end
          end
          S_YWAIT: st <= S_BURST;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r8_quiet: assert property (@(posedge aclk) disable iff (rst)
    !cfg_sync |=> (st == S_IDLE && $stable(dq_q)));
  a_r2_capture: assert property (@(posedge aclk) disable iff (rst)
    cap |=> (st == S_XWAIT && cnt == $past(addr) && xcnt == XONE));
  a_r3_wait_no_step: assert property (@(posedge aclk) disable iff (rst)
    (st == S_XWAIT && !cap) |=> $stable(cnt));
  a_r6_low_keeps_dq: assert property (@(posedge aclk) disable iff (rst)
    (st == S_XWAIT && !x_done) |=> $stable(dq_q));
  a_r4_step: assert property (@(posedge aclk) disable iff (rst)
    (adv_go && cfg_sync) |=> cnt == $past(cnt) + AW'(1));
  a_r5_hold: assert property (@(posedge aclk) disable iff (rst)
    (st == S_BURST && adv_n && !cap) |=> ($stable(cnt) && $stable(dq_q)));
  a_r5_yslot: assert property (@(posedge aclk) disable iff (rst)
    (st == S_YWAIT && cfg_sync && !cap) |=> (st == S_BURST && $stable(cnt)));
endmodule

// File: tb/burst_rd_seq_tb_top.sv
`timescale 1ns/1ps
module burst_rd_seq_tb_top;
  logic clk = 0, rst = 1, cfg_sync = 1, cfg_fall = 0, cfg_ylat2 = 0, cfg_rdy_early = 0;
  logic le_n = 1, adv_n = 1;
  logic [2:0]  cfg_xlat = 3'd3;
  logic [18:0] addr = '0;
  logic [18:0] mem_addr;
  logic [31:0] mem_rdata, dq;
  logic rdy, rdy_oe, aclk;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [31:0] rom(input logic [18:0] a);
    return {a[12:0], a} ^ 32'hA5C3_0F96;
  endfunction

  always #4 clk = ~clk;
  assign aclk = clk ^ cfg_fall;
  assign mem_rdata = rom(mem_addr);

  burst_rd_seq dut_i (.clk(clk), .rst(rst), .cfg_sync(cfg_sync), .cfg_fall(cfg_fall),
    .cfg_xlat(cfg_xlat), .cfg_ylat2(cfg_ylat2), .cfg_rdy_early(cfg_rdy_early),
    .le_n(le_n), .addr(addr), .adv_n(adv_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dq(dq), .rdy(rdy), .rdy_oe(rdy_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle model built from the requirements
  int ms = 0, mx = 0;
  logic [18:0] mcnt = '0;
  logic [31:0] mdq = '0;
  logic mleq = 1;

  task automatic mstep();
    int xl;
    bit cap;
    xl = (cfg_xlat < 2) ? 2 : int'(cfg_xlat);
    if (rst) begin
      ms = 0; mcnt = '0; mdq = '0; mleq = 1;
    end else if (!cfg_sync) begin
      ms = 0; mleq = 1;
    end else begin
      cap = !le_n && mleq;
      mleq = le_n;
      if (cap) begin
        ms = 1; mx = 1; mcnt = addr;
      end else if (ms == 1) begin
        if (mx == xl) begin ms = 2; mdq = rom(mcnt); end
        else mx++;
      end else if (ms == 2) begin
        if (!adv_n) begin mcnt = mcnt + 19'd1; mdq = rom(mcnt); end
        else if (cfg_ylat2) ms = 3;
      end else if (ms == 3) ms = 2;
    end
  endtask

  function automatic logic exp_rdy();
    int xl;
    xl = (cfg_xlat < 2) ? 2 : int'(cfg_xlat);
    return cfg_sync && (ms >= 2 || (cfg_rdy_early && ms == 1 && mx == xl));
  endfunction

  always @(posedge aclk) begin
    #1 mstep();
    #4;
    if (!rst && !done) begin
      chk("R4 dq model", dq, mdq);
      chk("R6 rdy model", {31'd0, rdy}, {31'd0, exp_rdy()});
      chk("R8 rdy_oe model", {31'd0, rdy_oe}, {31'd0, cfg_sync});
    end
  end

  task automatic tick();
    @(posedge aclk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    tick(); tick();
    chk("R10 reset dq", dq, 0);
    chk("R10 reset rdy", {31'd0, rdy}, 0);
    chk("R10 reset mem_addr", {13'd0, mem_addr}, 0);
    rst = 0;
    // wrap and latency
    le_n = 0; addr = 19'h7FFFE; tick(); le_n = 1;
    tick(); chk("R6 rdy low in wait", {31'd0, rdy}, 0);
    adv_n = 0;
    tick(); chk("R6 dq kept while low", dq, 0);
    chk("R3 advance ignored in wait", {13'd0, mem_addr}, 32'h7FFFE);
    tick(); chk("R3 first word", dq, rom(19'h7FFFE));
    chk("R6 rdy high", {31'd0, rdy}, 1);
    tick(); chk("R4 next word", dq, rom(19'h7FFFF));
    tick(); chk("R9 wrap word", dq, rom(19'h00000));
    chk("R9 wrap address", {13'd0, mem_addr}, 1);
    // inter-word latency of 2
    adv_n = 1; cfg_ylat2 = 1;
    tick(); chk("R5 hold word", dq, rom(19'h0));
    adv_n = 0;
    tick(); chk("R5 advance ignored in y slot", dq, rom(19'h0));
    tick(); chk("R5 advance after y slot", dq, rom(19'h1));
    adv_n = 1; cfg_ylat2 = 0;
    // capture during burst, latency code 0, early ready
    cfg_xlat = 3'd0; cfg_rdy_early = 1;
    le_n = 0; addr = 19'd100;
    tick(); chk("R2 abort drops rdy", {31'd0, rdy}, 0);
    tick(); chk("R7 early rdy", {31'd0, rdy}, 1);
    chk("R6 dq kept", dq, rom(19'h1));
    tick(); chk("R3 code 0 acts as 2, R2 held le_n no restart", dq, rom(19'd100));
    le_n = 1; cfg_rdy_early = 0;
    // sync mode off
    cfg_sync = 0;
    tick(); chk("R8 rdy_oe off", {31'd0, rdy_oe}, 0);
    chk("R8 rdy off", {31'd0, rdy}, 0);
    le_n = 0; addr = 19'd5; adv_n = 0;
    tick(); tick(); le_n = 1; adv_n = 1;
    chk("R8 inputs ignored", dq, rom(19'd100));
    cfg_sync = 1;
    tick(); chk("R8 idle after reenable", {31'd0, rdy}, 0);
    // falling active edge
    rst = 1; cfg_fall = 1; tick(); tick(); tick(); rst = 0;
    cfg_xlat = 3'd2;
    le_n = 0; addr = 19'd9; tick(); le_n = 1;
    tick(); tick();
    chk("R1 falling edge word", dq, rom(19'd9));
    chk("R1 clk low after active edge", {31'd0, clk}, 0);
    // constrained random segments
    for (int s = 0; s < 24; s++) begin
      rst = 1; cfg_sync = 1;
      cfg_fall = 1'($urandom % 2); cfg_xlat = 3'($urandom % 8);
      cfg_ylat2 = 1'($urandom % 2); cfg_rdy_early = 1'($urandom % 2);
      tick(); tick(); tick();
      rst = 0;
      for (int c = 0; c < 300; c++) begin
        le_n  = ($urandom % 10) != 0;
        addr  = (($urandom % 4) == 0) ? 19'h7FFFF - 19'($urandom % 3) : 19'($urandom);
        adv_n = ($urandom % 3) == 0;
        if (($urandom % 80) == 0) cfg_sync = ~cfg_sync;
        if (($urandom % 60) == 0) cfg_ylat2 = ~cfg_ylat2;
        tick();
      end
    end
    finish_run();
  end
endmodule